// File: doc/BRIEF.md
# Sampled-Edge 16-bit Timer/Counter

This block is a 16-bit timer/counter for a small microcontroller-style core. A free-running prescaler splits the oscillator clock into machine cycles of twelve clocks. When it runs as a timer, the count advances once in each machine cycle. When it runs as an event counter, it advances once for each high-to-low transition of an external count pin. The pin is seen only through one sample taken per machine cycle, so the fastest input it can follow toggles every twelve clocks, which is one count per twenty-four clocks.

A 16-bit capture/reload pair adds two modes. In auto-reload mode the counter counts up or down and reloads at the end of its range. In capture mode a falling edge on an external trigger pin copies the live count into the pair and the counter keeps running. Two sticky flags, overflow and external event, stay set until software clears them. The overflow flag is also driven on a pin. Software reaches every register through a byte-wide register port with synchronous writes and combinational reads.

Top module: `edge_timer16`

## Requirements
- R1: After reset every register at addresses 0 to 7 reads 0x00 and `overflowFlag` is low.
- R2: The register map is: 0 control, 1 count low byte, 2 count high byte, 3 capture/reload low byte, 4 capture/reload high byte. Control bits are: 0 run, 1 counter function (0 = timer), 2 capture mode (0 = auto-reload), 3 count down, 4 trigger enable, 5 reads 0, 6 event flag, 7 overflow flag. Writes are stored on the clock edge and reads back the stored value. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R3: In timer function with run set, the count advances exactly once per 12 clocks. With run clear, the count does not change.
- R4: In counter function with run set, the count pin is sampled once per machine cycle. The count advances once for each pair of consecutive samples that reads high and then low. A train whose levels are each held for at least 12 clocks is counted in full, so a 12-high/12-low train is counted at one step per 24 clocks. A pin held at one level adds nothing.
- R5: After the count pin falls, the count does not change within the next three clock edges, and it has advanced by the sixteenth edge.
- R6: In auto-reload up mode (bit 2 = 0, bit 3 = 0), a step from 0xFFFF loads the capture/reload value and sets the overflow flag. Any other step adds one.
- R7: In auto-reload down mode (bit 2 = 0, bit 3 = 1), a step taken while the count equals the capture/reload value loads 0xFFFF and sets the overflow flag. Any other step subtracts one.
- R8: In capture mode the counter always counts up, whatever bit 3 holds. A step from 0xFFFF wraps to 0x0000 and sets the overflow flag.
- R9: In capture mode with trigger enable set, a sampled falling edge on the trigger pin copies the count into the capture/reload pair and sets the event flag. This happens whether or not run is set, and the counter keeps counting through it.
- R10: A trigger edge changes neither the capture/reload pair nor the event flag when capture mode is clear or trigger enable is clear.
- R11: Both flags stay set until software writes 0 to their control bit. Writing 1 to a flag bit leaves it unchanged.
- R12: `overflowFlag` always equals control bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| countPin | input | 1 | External event input, counted on falling edges |
| trigPin | input | 1 | External capture trigger, acts on falling edges |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data for `addr` |
| overflowFlag | output | 1 | Sticky overflow flag |

## Verification
The bench targets the seams of the range: 0xFFFF in up and capture counting, and the reload value in down counting. A design that compared against the wrong end, or reloaded one step late, would leave a count off by one or a wrong reload image after a reload. Event trains that run at the maximum rate expose an edge detector that needs more than one sample per level, because it would drop counts. Trigger edges given with run cleared, with the mode wrong, or with the trigger disabled show whether a capture is gated correctly. A capture while running shows whether capturing disturbs the count. Flag writes with a mix of ones and zeros catch a clear that hits the wrong flag or one that does not last.

// File: rtl/edge_timer16_pkg.sv
package edge_timer16_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int CFG_W  = 5;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;

  localparam int B_RUN  = 0;
  localparam int B_CSEL = 1;
  localparam int B_CAPM = 2;
  localparam int B_DOWN = 3;
  localparam int B_TRIG = 4;
  localparam int B_EVT  = 6;
  localparam int B_OVF  = 7;

  // packed MSB first so that a cast from control bits [4:0] lines up
  typedef struct packed {
    logic trigEn;
    logic down;
    logic capMode;
    logic countSel;
    logic run;
  } tmrCfg_t;

  typedef struct packed {
    logic step;
    logic capture;
  } tmrStrobe_t;
endpackage

// File: rtl/edge_timer16_ctrl.sv
module edge_timer16_ctrl
  import edge_timer16_pkg::*;
#(
  parameter int PRESCALE     = 12,
  parameter int SAMPLE_PHASE = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countPin,
  input  logic             trigPin,
  input  logic             wrCtrl,
  input  logic [CFG_W-1:0] cfgBits,
  output tmrCfg_t          cfg,
  output tmrStrobe_t       strobes
);
  localparam int PH_W = $clog2(PRESCALE);
  localparam int NPIN = 2;  // index 0: count pin, index 1: trigger pin

  logic [PH_W-1:0] phase;
  logic            mcTick;
  logic            sampleNow;
  logic [NPIN-1:0] pinIn;
  logic [NPIN-1:0] fallSeen;

  assign mcTick    = (phase == PH_W'(PRESCALE - 1));
  assign sampleNow = (phase == PH_W'(SAMPLE_PHASE));
  assign pinIn     = {trigPin, countPin};

  // machine-cycle prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       phase <= '0;
    else if (mcTick) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cfg <= '0;
    else if (wrCtrl) cfg <= tmrCfg_t'(cfgBits);
  end

  // per-pin synchronizer and once-per-machine-cycle sampler
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   curS;
    logic                   prevS;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '0;
        curS  <= 1'b0;
        prevS <= 1'b0;
      end else begin
        syncQ[0] <= pinIn[p];
        for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
        if (sampleNow) begin
          curS  <= syncQ[SYNC_STAGES-1];
          prevS <= curS;
        end
      end
    end

    // valid from one sample to the next; exactly one tick falls in between
    assign fallSeen[p] = prevS & ~curS;
  end

  assign strobes.step    = mcTick & cfg.run & (cfg.countSel ? fallSeen[0] : 1'b1);
  assign strobes.capture = mcTick & cfg.capMode & cfg.trigEn & fallSeen[1];

  // R3: the machine cycle restarts right after its last clock
  a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rstN)
    mcTick |=> (phase == '0));

  // R3: ticks are never adjacent
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    mcTick |=> !mcTick);

  // R4: one sampled edge gives one step, never a burst
  a_r4_single_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> !strobes.step);

  // R9: a capture strobe never repeats on the next clock
  a_r9_single_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> !strobes.capture);
endmodule

// File: rtl/edge_timer16_dp.sv
module edge_timer16_dp
  import edge_timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tmrCfg_t           cfg,
  input  tmrStrobe_t        strobes,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              ovfOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] capReg;
  logic [CNT_W-1:0] stepVal;
  logic             wrapHit;
  logic             ovf;
  logic             evt;
  logic             wrCtrl, wrCntLo, wrCntHi, wrCapLo, wrCapHi;
  logic             cntWrite, capWrite, stepApplied, capApplied;

  assign wrCtrl   = wrEn && (addr == A_CTRL);
  assign wrCntLo  = wrEn && (addr == A_CNT_LO);
  assign wrCntHi  = wrEn && (addr == A_CNT_HI);
  assign wrCapLo  = wrEn && (addr == A_CAP_LO);
  assign wrCapHi  = wrEn && (addr == A_CAP_HI);
  assign cntWrite = wrCntLo | wrCntHi;
  assign capWrite = wrCapLo | wrCapHi;

  // a software write to a register beats the hardware update in that cycle
  assign stepApplied = strobes.step & ~cntWrite;
  assign capApplied  = strobes.capture & ~capWrite;

  // next count for one step, per mode
  always_comb begin
    if (cfg.capMode) begin
      wrapHit = (cnt == CNT_MAX);
      stepVal = cnt + 1'b1;
    end else if (cfg.down) begin
      wrapHit = (cnt == capReg);
      stepVal = wrapHit ? CNT_MAX : cnt - 1'b1;
    end else begin
      wrapHit = (cnt == CNT_MAX);
      stepVal = wrapHit ? capReg : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (wrCntLo)     cnt[BYTE_W-1:0] <= wrData;
    else if (wrCntHi)     cnt[CNT_W-1:BYTE_W] <= wrData;
    else if (stepApplied) cnt <= stepVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           capReg <= '0;
    else if (wrCapLo)    capReg[BYTE_W-1:0] <= wrData;
    else if (wrCapHi)    capReg[CNT_W-1:BYTE_W] <= wrData;
    else if (capApplied) capReg <= cnt;
  end

  // sticky flags: a hardware set wins over a software clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovf <= 1'b0;
      evt <= 1'b0;
    end else begin
      if (stepApplied && wrapHit)      ovf <= 1'b1;
      else if (wrCtrl && !wrData[B_OVF]) ovf <= 1'b0;
      if (capApplied)                  evt <= 1'b1;
      else if (wrCtrl && !wrData[B_EVT]) evt <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL: begin
        rdData[B_RUN]  = cfg.run;
        rdData[B_CSEL] = cfg.countSel;
        rdData[B_CAPM] = cfg.capMode;
        rdData[B_DOWN] = cfg.down;
        rdData[B_TRIG] = cfg.trigEn;
        rdData[B_EVT]  = evt;
        rdData[B_OVF]  = ovf;
      end
      A_CNT_LO: rdData = cnt[BYTE_W-1:0];
      A_CNT_HI: rdData = cnt[CNT_W-1:BYTE_W];
      A_CAP_LO: rdData = capReg[BYTE_W-1:0];
      A_CAP_HI: rdData = capReg[CNT_W-1:BYTE_W];
      default:  rdData = '0;
    endcase
  end

  assign ovfOut = ovf;

  // R3: a stopped counter holds unless software writes it
  a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.run && !cntWrite) |=> $stable(cnt));

  // R6: up reload takes the reload image and flags overflow
  a_r6_up_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stepApplied && !cfg.capMode && !cfg.down && cnt == CNT_MAX)
      |=> (cnt == $past(capReg) && ovf));

  // R7: down count reaching the reload value restarts from all ones
  a_r7_down_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stepApplied && !cfg.capMode && cfg.down && cnt == capReg)
      |=> (cnt == CNT_MAX && ovf));

  // R8: capture-mode counting wraps to zero
  a_r8_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stepApplied && cfg.capMode && cnt == CNT_MAX) |=> (cnt == '0 && ovf));

  // R9: a capture holds the pre-edge count and raises the event flag
  a_r9_capture_value: assert property (@(posedge clk) disable iff (!rstN)
    capApplied |=> (capReg == $past(cnt) && evt));

  // R11: overflow flag persists without a clearing write
  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !(wrCtrl && !wrData[B_OVF])) |=> ovf);
endmodule

// File: rtl/edge_timer16.sv
module edge_timer16
  import edge_timer16_pkg::*;
#(
  parameter int PRESCALE     = 12,
  parameter int SAMPLE_PHASE = 9,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       countPin,
  input  logic       trigPin,
  input  logic       wrEn,
  input  logic [2:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       overflowFlag
);
  tmrCfg_t    cfg;
  tmrStrobe_t strobes;
  logic       wrCtrl;

  assign wrCtrl = wrEn && (addr == A_CTRL);

  edge_timer16_ctrl #(
    .PRESCALE    (PRESCALE),
    .SAMPLE_PHASE(SAMPLE_PHASE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .countPin(countPin),
    .trigPin (trigPin),
    .wrCtrl  (wrCtrl),
    .cfgBits (wrData[CFG_W-1:0]),
    .cfg     (cfg),
    .strobes (strobes)
  );

  edge_timer16_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .strobes(strobes),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .ovfOut (overflowFlag)
  );
endmodule

// File: tb/edge_timer16_bench.sv
module edge_timer16_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2, A_RLO = 3'd3, A_RHI = 3'd4;
  localparam logic [7:0] M_RUN = 8'h01, M_CSEL = 8'h02, M_CAPM = 8'h04,
                         M_DOWN = 8'h08, M_TRIG = 8'h10, M_KEEP = 8'hC0;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       countPin = 1'b0;
  logic       trigPin = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  wire  [7:0] rdData;
  wire        overflowFlag;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  edge_timer16 u_edge_timer16 (
    .clk(clk), .rstN(rstN), .countPin(countPin), .trigPin(trigPin),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .overflowFlag(overflowFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic rd16(input logic [2:0] aLo, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(aLo, lo);
    rd(aLo + 3'd1, hi);
    v = {hi, lo};
  endtask

  task automatic setup(input logic [7:0] mode, input logic [15:0] c, input logic [15:0] r);
    wr(A_CTRL, mode);
    wr(A_CLO, c[7:0]); wr(A_CHI, c[15:8]);
    wr(A_RLO, r[7:0]); wr(A_RHI, r[15:8]);
  endtask

  // run for exactly k machine cycles worth of clock edges
  task automatic runTicks(input logic [7:0] mode, input int k);
    wr(A_CTRL, mode | M_RUN | M_KEEP);
    repeat (12 * k - 2) @(negedge clk);
    wr(A_CTRL, mode | M_KEEP);
  endtask

  task automatic pulse(input bit onTrig, input int hi, input int lo);
    if (onTrig) trigPin = 1'b1; else countPin = 1'b1;
    repeat (hi) @(negedge clk);
    if (onTrig) trigPin = 1'b0; else countPin = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  function automatic logic [16:0] modelStep(logic [15:0] c, logic [15:0] r, logic capM, logic dn);
    if (capM)      return {c == 16'hFFFF, c + 16'd1};
    else if (dn)   return (c == r) ? {1'b1, 16'hFFFF} : {1'b0, c - 16'd1};
    else           return (c == 16'hFFFF) ? {1'b1, r} : {1'b0, c + 16'd1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, v2;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), b);
      chk("R1 reset register", b, 8'h00);
    end
    chk("R1 reset flag pin", overflowFlag, 1'b0);

    // R2 register map and readback
    setup(8'h1E, 16'hA55A, 16'h3CC3);
    rd(A_CTRL, b); chk("R2 control readback", b, 8'h1E);
    rd16(A_CLO, v); chk("R2 count readback", v, 16'hA55A);
    rd16(A_RLO, v); chk("R2 reload readback", v, 16'h3CC3);
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd5, b); chk("R2 unused address reads zero", b, 8'h00);
    rd(3'd7, b); chk("R2 unused address reads zero", b, 8'h00);
    rd16(A_CLO, v); chk("R2 unused write leaves count", v, 16'hA55A);
    rd(A_CTRL, b); chk("R2 unused write leaves control", b, 8'h1E);

    // R3 stopped counter holds, running timer steps once per 12 clocks
    setup(8'h00, 16'h1234, 16'h0000);
    repeat (48) @(negedge clk);
    rd16(A_CLO, v); chk("R3 stopped holds", v, 16'h1234);
    runTicks(8'h00, 7);
    rd16(A_CLO, v); chk("R3 timer seven cycles", v, 16'h123B);

    // R6 up reload, R12 flag pin, R11 sticky then clear
    setup(8'h00, 16'hFFFE, 16'hFFF0);
    runTicks(8'h00, 4);
    rd16(A_CLO, v); chk("R6 up reload value", v, 16'hFFF2);
    rd(A_CTRL, b); chk("R6 overflow bit", b[7], 1'b1);
    chk("R12 flag pin follows bit", overflowFlag, 1'b1);
    runTicks(8'h00, 2);
    rd16(A_CLO, v); chk("R11 counting continues", v, 16'hFFF4);
    rd(A_CTRL, b); chk("R11 overflow stays set", b[7], 1'b1);
    wr(A_CTRL, 8'h40);
    rd(A_CTRL, b); chk("R11 overflow cleared by zero", b[7], 1'b0);
    chk("R12 flag pin cleared", overflowFlag, 1'b0);

    // R7 down reload
    setup(M_DOWN, 16'h0007, 16'h0005);
    runTicks(M_DOWN, 5);
    rd16(A_CLO, v); chk("R7 down reload value", v, 16'hFFFD);
    rd(A_CTRL, b); chk("R7 overflow bit", b[7], 1'b1);

    // R8 capture mode counts up and wraps to zero even with down set
    setup(M_CAPM | M_DOWN, 16'hFFFE, 16'h7777);
    runTicks(M_CAPM | M_DOWN, 3);
    rd16(A_CLO, v); chk("R8 wrap to zero", v, 16'h0001);
    rd(A_CTRL, b); chk("R8 overflow bit", b[7], 1'b1);

    // R3 R6 R7 R8 constrained random timer runs
    for (int i = 0; i < 16; i++) begin
      int sel; int k; logic [7:0] mode; logic [15:0] r, c, e; logic eo; logic [16:0] s;
      sel = $urandom_range(0, 2);
      k = $urandom_range(1, 24);
      r = 16'($urandom);
      mode = (sel == 0) ? 8'h00 : (sel == 1) ? M_DOWN : (M_CAPM | ($urandom_range(0, 1) ? M_DOWN : 8'h00));
      c = (sel == 1) ? r + 16'($urandom_range(0, 10)) : 16'hFFFF - 16'($urandom_range(0, 10));
      setup(mode, c, r);
      runTicks(mode, k);
      e = c; eo = 1'b0;
      for (int n = 0; n < k; n++) begin
        s = modelStep(e, r, mode[2], mode[3]);
        e = s[15:0]; eo = eo | s[16];
      end
      rd16(A_CLO, v);
      chk(sel == 0 ? "R3 R6 random count" : sel == 1 ? "R3 R7 random count" : "R3 R8 random count", v, e);
      rd(A_CTRL, b);
      chk("R6 R7 R8 random overflow bit", b[7], eo);
      chk("R12 random flag pin", overflowFlag, eo);
    end

    // R4 steady high level adds nothing, the fall then counts one
    setup(M_CSEL, 16'h0040, 16'h0000);
    repeat (30) @(negedge clk);
    wr(A_CTRL, M_CSEL | M_RUN | M_KEEP);
    countPin = 1'b1;
    repeat (60) @(negedge clk);
    rd16(A_CLO, v); chk("R4 steady level no count", v, 16'h0040);
    countPin = 1'b0;
    repeat (30) @(negedge clk);
    wr(A_CTRL, M_CSEL | M_KEEP);
    rd16(A_CLO, v); chk("R4 single fall counted", v, 16'h0041);

    // R4 maximum rate train of 12 high / 12 low
    setup(M_CSEL, 16'h0000, 16'h0000);
    repeat (30) @(negedge clk);
    wr(A_CTRL, M_CSEL | M_RUN | M_KEEP);
    for (int n = 0; n < 8; n++) pulse(1'b0, 12, 12);
    repeat (30) @(negedge clk);
    wr(A_CTRL, M_CSEL | M_KEEP);
    rd16(A_CLO, v); chk("R4 max rate train", v, 16'h0008);

    // R4 random trains in random modes
    for (int i = 0; i < 6; i++) begin
      int sel; int nEdge; logic [7:0] mode; logic [15:0] r, c, e; logic eo; logic [16:0] s;
      sel = $urandom_range(0, 2);
      nEdge = $urandom_range(1, 6);
      r = 16'($urandom);
      mode = M_CSEL | ((sel == 0) ? 8'h00 : (sel == 1) ? M_DOWN : M_CAPM);
      c = (sel == 1) ? r + 16'($urandom_range(0, 4)) : 16'hFFFF - 16'($urandom_range(0, 4));
      setup(mode, c, r);
      repeat (30) @(negedge clk);
      wr(A_CTRL, mode | M_RUN | M_KEEP);
      for (int n = 0; n < nEdge; n++) pulse(1'b0, $urandom_range(12, 20), $urandom_range(12, 20));
      repeat (30) @(negedge clk);
      wr(A_CTRL, mode | M_KEEP);
      e = c; eo = 1'b0;
      for (int n = 0; n < nEdge; n++) begin
        s = modelStep(e, r, mode[2], mode[3]);
        e = s[15:0]; eo = eo | s[16];
      end
      rd16(A_CLO, v); chk("R4 random train count", v, e);
      rd(A_CTRL, b); chk("R4 random train overflow", b[7], eo);
    end

    // R5 latency of a counted edge
    setup(M_CSEL, 16'h0010, 16'h0000);
    repeat (30) @(negedge clk);
    wr(A_CTRL, M_CSEL | M_RUN | M_KEEP);
    countPin = 1'b1;
    repeat (30) @(negedge clk);
    addr = A_CLO;
    countPin = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R5 not before fourth edge", rdData, 8'h10);
    repeat (13) @(negedge clk);
    #1 chk("R5 visible by sixteenth edge", rdData, 8'h11);
    wr(A_CTRL, M_CSEL | M_KEEP);

    // R9 capture while stopped
    setup(M_CAPM | M_TRIG, 16'hBEEF, 16'h0000);
    repeat (30) @(negedge clk);
    pulse(1'b1, 24, 30);
    rd16(A_RLO, v); chk("R9 captured stopped count", v, 16'hBEEF);
    rd(A_CTRL, b); chk("R9 event flag set", b[6], 1'b1);
    rd16(A_CLO, v); chk("R9 count untouched", v, 16'hBEEF);
    wr(A_CTRL, 8'h80 | M_CAPM | M_TRIG);
    rd(A_CTRL, b); chk("R11 event cleared by zero", b[6], 1'b0);

    // R9 capture while running, counter keeps going
    setup(M_CAPM | M_TRIG, 16'h0100, 16'h0000);
    repeat (30) @(negedge clk);
    fork
      runTicks(M_CAPM | M_TRIG, 10);
      begin
        repeat (20) @(negedge clk);
        pulse(1'b1, 24, 30);
      end
    join
    rd16(A_CLO, v); chk("R9 counter kept running", v, 16'h010A);
    rd16(A_RLO, v2);
    chk("R9 running capture in range", (v2 > 16'h0100) && (v2 < 16'h010A), 1'b1);
    rd(A_CTRL, b); chk("R9 running event flag", b[6], 1'b1);

    // R10 trigger ignored in auto-reload mode and with trigger disabled
    setup(M_TRIG, 16'h2222, 16'h5555);
    repeat (30) @(negedge clk);
    pulse(1'b1, 24, 30);
    rd16(A_RLO, v); chk("R10 reload mode no capture", v, 16'h5555);
    rd(A_CTRL, b); chk("R10 reload mode no event", b[6], 1'b0);
    setup(M_CAPM, 16'h3333, 16'h6666);
    repeat (30) @(negedge clk);
    pulse(1'b1, 24, 30);
    rd16(A_RLO, v); chk("R10 trigger disabled no capture", v, 16'h6666);
    rd(A_CTRL, b); chk("R10 trigger disabled no event", b[6], 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule